// File: doc/BRIEF.md
# Bit-Configurable GPIO Port Controller

This block holds the configuration of one general-purpose I/O port of parameterised width (eight bits by default). Each bit has three controls written over a simple synchronous register bus: a direction bit, a stored output value, and a mode bit. When the mode bit is set, the bit belongs to a peripheral alternate function. The block drives pin output values and output enables. In alternate mode it passes the peripheral's output value and enable straight to the pin. It returns read data whose source, for each bit, depends on the direction setting.

Pin inputs pass through a synchroniser before they reach the read path or the peripheral inputs. Read data is driven only while a read access is active and is zero otherwise. An input-only build removes the output drivers and the direction and output-value storage. A low-power indication does not disturb any stored setting. In particular the mode bits keep their values across entry to and exit from low power, and every register remains writable while low power is asserted.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction, output-value and mode registers read as zero, every pin output enable is 0, and every pin output value is 0.
- R2: For a bit whose mode bit is 0, pin_oe equals the direction bit and pin_out equals the stored output value. A direction bit of 1 means output and 0 means input.
- R3: A read at address 0 returns, for each bit, the stored output value when that bit's direction is 1, and the synchronised pin level when it is 0. This holds in both general and alternate mode.
- R4: bus_rdata is all zero in every cycle in which bus_rd_en is 0.
- R5: For a bit whose mode bit is 1, pin_out equals alt_out and pin_oe equals alt_oe for that bit.
- R6: alt_in carries the synchronised pin level for bits whose mode bit is 1, and 0 for the other bits.
- R7: A change on pin_in first appears in read data and on alt_in after the second rising clock edge that follows it.
- R8: Raising or lowering lp_mode leaves the mode register unchanged, and writes to every register are accepted while lp_mode is 1.
- R9: With INPUT_ONLY set, pin_oe and pin_out stay 0, a direction read returns 0 whatever has been written, and an address-0 read always returns the synchronised pin level.
- R10: Address 1 reads and writes the direction register and address 2 the mode register. Address 3 reads as 0, and writes to it change no register.
- R11: A register write presented before a rising edge takes effect on that edge and is not visible before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_mode | input | 1 | Low-power indication; retains all settings |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 port data, 1 direction, 2 mode, 3 unused |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, zero when no read is active |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad output enables |
| alt_out | input | WIDTH | Peripheral output values for alternate mode |
| alt_oe | input | WIDTH | Peripheral output enables for alternate mode |
| alt_in | output | WIDTH | Synchronised pin levels forwarded to peripherals |

## Verification
The bench builds two copies side by side and drives both from one bus and one set of pins. The first copy uses the default eight-bit bidirectional build, with two synchroniser stages. The second sets INPUT_ONLY, so every vector also shows that this copy ignores direction and output writes while its mode bits and read path keep working. With two stages, the exact cycle of the input latency can be checked. It also makes the latency assertion inside the synchroniser active.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int GPIO_ADDR_W = 2;

   typedef enum logic [GPIO_ADDR_W-1:0] {
      REG_PORT = 2'd0,
      REG_DIR  = 2'd1,
      REG_MODE = 2'd2,
      REG_NONE = 2'd3
   } gpio_reg_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_sync
);

   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= pin_in;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign pin_sync = stg[LAST];

   generate
      if (STAGES == 2) begin : g_lat_chk
         logic [1:0] fill;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            fill <= '0;
            else if (fill != 2'd2) fill <= fill + 2'd1;
         end
         AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (fill == 2'd2) |-> (pin_sync == $past(pin_in, 2))); // R7
      end
   endgenerate

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit INPUT_ONLY = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lp_mode,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [GPIO_ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]       wdata,
   input  logic [WIDTH-1:0]       pin_sync,
   output logic [WIDTH-1:0]       rdata,
   output logic [WIDTH-1:0]       dir_q,
   output logic [WIDTH-1:0]       data_q,
   output logic [WIDTH-1:0]       mode_q
);

   gpio_reg_e sel;
   logic      wr_mode;

   assign sel     = gpio_reg_e'(addr);
   assign wr_mode = wr_en && (sel == REG_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= wdata;
   end

   AST_MODE_KEEP_LP: assert property (@(posedge clk) disable iff (!rst_n)
      ((lp_mode != $past(lp_mode)) && !wr_mode) |=> $stable(mode_q)); // R8

   generate
      if (INPUT_ONLY) begin : g_ro
         assign dir_q  = '0;
         assign data_q = '0;
      end else begin : g_rw
         logic wr_dir;
         logic wr_data;

         assign wr_dir  = wr_en && (sel == REG_DIR);
         assign wr_data = wr_en && (sel == REG_PORT);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dir_q  <= '0;
               data_q <= '0;
            end else begin
               if (wr_dir)  dir_q  <= wdata;
               if (wr_data) data_q <= wdata;
            end
         end

         AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_dir |=> (dir_q == $past(wdata))); // R11
      end
   endgenerate

   logic [WIDTH-1:0] rd_sel;

   always_comb begin
      case (sel)
         REG_PORT: rd_sel = (dir_q & data_q) | (~dir_q & pin_sync);
         REG_DIR:  rd_sel = dir_q;
         REG_MODE: rd_sel = mode_q;
         default:  rd_sel = '0;
      endcase
   end

   assign rdata = rd_en ? rd_sel : '0;

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int WIDTH      = 8,
   parameter bit INPUT_ONLY = 1'b0
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] mode_q,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] alt_out,
   input  logic [WIDTH-1:0] alt_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] alt_in
);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (INPUT_ONLY) begin : g_ro
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = 1'b0;
         end else begin : g_rw
            assign pin_out[i] = mode_q[i] ? alt_out[i] : data_q[i];
            assign pin_oe[i]  = mode_q[i] ? alt_oe[i]  : dir_q[i];
         end
         assign alt_in[i] = mode_q[i] & pin_sync[i];
      end
   endgenerate

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit INPUT_ONLY  = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lp_mode,
   input  logic                   bus_wr_en,
   input  logic                   bus_rd_en,
   input  logic [GPIO_ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]       bus_wdata,
   output logic [WIDTH-1:0]       bus_rdata,
   input  logic [WIDTH-1:0]       pin_in,
   output logic [WIDTH-1:0]       pin_out,
   output logic [WIDTH-1:0]       pin_oe,
   input  logic [WIDTH-1:0]       alt_out,
   input  logic [WIDTH-1:0]       alt_oe,
   output logic [WIDTH-1:0]       alt_in
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_port_ctrl: WIDTH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] mode_q;

   gpio_in_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .pin_sync (pin_sync)
   );

   gpio_cfg_regs #(
      .WIDTH      (WIDTH),
      .INPUT_ONLY (INPUT_ONLY)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_mode  (lp_mode),
      .wr_en    (bus_wr_en),
      .rd_en    (bus_rd_en),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync),
      .rdata    (bus_rdata),
      .dir_q    (dir_q),
      .data_q   (data_q),
      .mode_q   (mode_q)
   );

   gpio_pin_mux #(
      .WIDTH      (WIDTH),
      .INPUT_ONLY (INPUT_ONLY)
   ) u_mux (
      .dir_q    (dir_q),
      .data_q   (data_q),
      .mode_q   (mode_q),
      .pin_sync (pin_sync),
      .alt_out  (alt_out),
      .alt_oe   (alt_oe),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .alt_in   (alt_in)
   );

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |-> (bus_rdata == '0)); // R4

   generate
      if (!INPUT_ONLY) begin : g_oe_chk
         AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && (bus_addr == REG_DIR))
            |=> (((pin_oe ^ $past(bus_wdata)) & ~mode_q) == '0)); // R2
      end
   endgenerate

endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         lp_mode = 1'b0;
   logic         bus_wr_en = 1'b0;
   logic         bus_rd_en = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] alt_out = '0;
   logic [W-1:0] alt_oe = '0;
   logic [W-1:0] bus_rdata, pin_out, pin_oe, alt_in;
   logic [W-1:0] ro_rdata, ro_pin_out, ro_pin_oe, ro_alt_in;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpio_port_ctrl #(.WIDTH(W), .SYNC_STAGES(2), .INPUT_ONLY(1'b0)) i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in));

   gpio_port_ctrl #(.WIDTH(W), .SYNC_STAGES(2), .INPUT_ONLY(1'b1)) i_gpio_port_ctrl_ro (
      .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(ro_rdata),
      .pin_in(pin_in), .pin_out(ro_pin_out), .pin_oe(ro_pin_oe),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(ro_alt_in));

   typedef struct packed {
      logic [7:0] dir, data, mode, pin, aout, aoe;
      logic [7:0] e_rd, e_out, e_oe, e_ain;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{8'h00, 8'hFF, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'hFF, 8'h00, 8'h00},
      '{8'hFF, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h3C, 8'hFF, 8'h00},
      '{8'hF0, 8'h5A, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h5F, 8'h5A, 8'hF0, 8'h00},
      '{8'h0F, 8'hFF, 8'h33, 8'hE1, 8'h11, 8'h22, 8'hEF, 8'hDD, 8'h2E, 8'h21},
      '{8'hAA, 8'h00, 8'hFF, 8'h55, 8'h96, 8'h69, 8'h55, 8'h96, 8'h69, 8'h55}
   };

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d, output logic [W-1:0] dro);
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = a;
      #5;
      d = bus_rdata; dro = ro_rdata;
      bus_rd_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] r, rro;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      rd(2'd1, r, rro); chk("R1 dir after reset", r, 8'h00);
      rd(2'd2, r, rro); chk("R1 mode after reset", r, 8'h00);
      chk("R1 pin_oe after reset", pin_oe, 8'h00);
      chk("R1 pin_out after reset", pin_out, 8'h00);

      // R4 idle read data
      #3; chk("R4 rdata idle", bus_rdata, 8'h00);

      // Vector table: R2 R3 R5 R6 R9
      for (int k = 0; k < NV; k++) begin
         wr(2'd1, VECS[k].dir);
         wr(2'd0, VECS[k].data);
         wr(2'd2, VECS[k].mode);
         @(negedge clk);
         pin_in = VECS[k].pin; alt_out = VECS[k].aout; alt_oe = VECS[k].aoe;
         repeat (3) @(negedge clk);
         chk($sformatf("R2/R5 pin_out vec%0d", k), pin_out, VECS[k].e_out);
         chk($sformatf("R2/R5 pin_oe vec%0d", k), pin_oe, VECS[k].e_oe);
         chk($sformatf("R6 alt_in vec%0d", k), alt_in, VECS[k].e_ain);
         chk($sformatf("R9 ro pin_oe vec%0d", k), ro_pin_oe, 8'h00);
         chk($sformatf("R9 ro pin_out vec%0d", k), ro_pin_out, 8'h00);
         chk($sformatf("R6 ro alt_in vec%0d", k), ro_alt_in, VECS[k].e_ain);
         rd(2'd0, r, rro);
         chk($sformatf("R3 port read vec%0d", k), r, VECS[k].e_rd);
         chk($sformatf("R9 ro port read vec%0d", k), rro, VECS[k].pin);
         rd(2'd1, r, rro);
         chk($sformatf("R10 dir read vec%0d", k), r, VECS[k].dir);
         chk($sformatf("R9 ro dir read vec%0d", k), rro, 8'h00);
      end

      // R10 unused address
      wr(2'd1, 8'h5A); wr(2'd2, 8'h00); wr(2'd0, 8'hC3);
      wr(2'd3, 8'hFF);
      rd(2'd3, r, rro); chk("R10 addr3 reads zero", r, 8'h00);
      rd(2'd1, r, rro); chk("R10 dir after addr3 write", r, 8'h5A);
      rd(2'd2, r, rro); chk("R10 mode after addr3 write", r, 8'h00);
      chk("R10 pin_out after addr3 write", pin_out, 8'hC3);

      // R11 write takes effect on the edge
      wr(2'd1, 8'h00);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h81;
      #5; chk("R11 oe before edge", pin_oe, 8'h00);
      @(posedge clk); #1; chk("R11 oe after edge", pin_oe, 8'h81);
      @(negedge clk); bus_wr_en = 1'b0;

      // R7 synchroniser latency
      wr(2'd1, 8'h00);
      @(negedge clk); pin_in = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'h3C;
      bus_rd_en = 1'b1; bus_addr = 2'd0;
      @(posedge clk); #1; chk("R7 one edge after change", bus_rdata, 8'h00);
      @(posedge clk); #1; chk("R7 two edges after change", bus_rdata, 8'h3C);
      @(negedge clk); bus_rd_en = 1'b0;

      // R8 low-power keeps mode and accepts writes
      wr(2'd2, 8'hA0);
      @(negedge clk); lp_mode = 1'b1;
      repeat (2) @(negedge clk);
      rd(2'd2, r, rro); chk("R8 mode kept on lp entry", r, 8'hA0);
      wr(2'd2, 8'h0F); wr(2'd1, 8'h55);
      rd(2'd2, r, rro); chk("R8 mode write in lp", r, 8'h0F);
      rd(2'd1, r, rro); chk("R8 dir write in lp", r, 8'h55);
      @(negedge clk); lp_mode = 1'b0;
      repeat (2) @(negedge clk);
      rd(2'd2, r, rro); chk("R8 mode kept on lp exit", r, 8'h0F);
      chk("R8 ro mode kept", rro, 8'h0F);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule